// File: doc/BRIEF.md
# Received word serial output link

This block hands one decoded 32-bit word at a time from an on-chip decoder to an external controller over a single data line. The controller supplies the shift clock. The decoder offers a word on a parallel port with a valid/ready handshake. Once the block accepts a word, it pulls the data line low. This tells the controller that a word is waiting. The controller then clocks the word out, most significant bit first. Each bit is placed on the line after a falling clock edge, and the controller samples it on the rising edge.

The controller may ignore a word or stop partway through it. To cover this, a receive window starts when the word is accepted. If the 32nd rising edge has not arrived when the window ends, the word is dropped and the block returns to idle with the line high. Three mode inputs choose the window length: the air standard, the majority-vote mode and whether the channel is the forward control channel. The window values are parameters counted in system clock cycles. While a word is held, the load port deasserts ready, so a second word waits at the decoder.

The external clock is slow: its period is never below 2 µs. It passes through a two-flop synchronizer, and its edges are detected in the system clock domain.

Top module: `rx_word_link`

## Requirements
- R1: After reset the data line `sd_out` is high and `ld_ready` is high.
- R2: In the cycle after a word is accepted (`ld_valid` and `ld_ready` high at a clock edge), `sd_out` goes low and `ld_ready` goes low. The line stays low until the first synchronized falling edge of `sck_in`.
- R3: The word is shifted out most significant bit first. Each bit appears on `sd_out` after a falling edge of `sck_in`. After the 32nd rising edge, the block returns to idle: the line is high and `ld_ready` is high.
- R4: The receive window selection is as follows. With `std_amps`=0 the block uses `WIN_T_NORM`. With `std_amps`=1 it uses `WIN_A_NORM`. When `maj_mode`=1 and `fwd_ctl`=1, the shortened values `WIN_T_MAJ` and `WIN_A_MAJ` are used instead.
- R5: When `maj_mode`=1 and `fwd_ctl`=0, the normal window for the selected standard applies.
- R6: If a word is not fully read, the block returns to idle exactly window-length cycles after acceptance. This applies both when no bit is read and when only some bits are read. The next word accepted is then delivered whole from its first bit.
- R7: While a word is held, `ld_ready` stays low. An offered word is not taken, and the held word is delivered unchanged.
- R8: Clock edges on `sck_in` while idle have no effect. The line stays high, and the next word loaded starts from its most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Decoder offers a word |
| ld_data | input | 32 | Word offered by the decoder |
| ld_ready | output | 1 | Block can accept a word |
| std_amps | input | 1 | 0 selects the first standard's windows, 1 the second's |
| maj_mode | input | 1 | Majority-vote mode |
| fwd_ctl | input | 1 | Channel is the forward control channel |
| sck_in | input | 1 | Shift clock from the external controller |
| sd_out | output | 1 | Serial data line, low means a word is waiting |

## Verification
Words are read out with patterns that separate bit-order and shift-timing errors. Alternating bits catch a missed or doubled shift. A single set bit at either end exposes reversed order or an off-by-one count. All-ones and all-zero words show whether the announce level and the idle level are being confused with data.

The window is measured in cycles for each mode combination. The majority mode off the forward channel is included, because it tells apart a decode that ignores the channel qualifier. Partial reads followed by a full read show whether the bit counter and the shift register really reset on expiry. Offering a word during a pending one, and toggling the clock while idle, check that neither changes the word eventually read.

// File: rtl/rx_word_link.sv
module rx_word_link #(
  parameter int W          = 32,
  parameter int WIN_T_NORM = 2350000,
  parameter int WIN_T_MAJ  = 1525000,
  parameter int WIN_A_NORM = 1850000,
  parameter int WIN_A_MAJ  = 1190000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  logic [W-1:0] ld_data,
  output logic         ld_ready,
  input  logic         std_amps,
  input  logic         maj_mode,
  input  logic         fwd_ctl,
  input  logic         sck_in,
  output logic         sd_out
);

  localparam int MAX_A = (WIN_T_NORM > WIN_T_MAJ) ? WIN_T_NORM : WIN_T_MAJ;
  localparam int MAX_B = (WIN_A_NORM > WIN_A_MAJ) ? WIN_A_NORM : WIN_A_MAJ;
  localparam int WMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(WMAX + 1);
  localparam int BW    = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_SHIFT} st_t;

  st_t           st;
  logic [W-1:0]  sh;
  logic [BW-1:0] bc;
  logic [CW-1:0] cnt;
  logic [CW-1:0] win;
  logic [2:0]    sy;
  logic          fall, rise, expire;

  always_ff @(posedge clk)
    if (!rst_n) sy <= 3'b111;
    else        sy <= {sy[1:0], sck_in};

  assign fall = sy[2] & ~sy[1];
  assign rise = ~sy[2] & sy[1];

  always_comb begin
    if (std_amps) win = (maj_mode && fwd_ctl) ? CW'(WIN_A_MAJ) : CW'(WIN_A_NORM);
    else          win = (maj_mode && fwd_ctl) ? CW'(WIN_T_MAJ) : CW'(WIN_T_NORM);
  end

  assign expire   = (cnt == win - CW'(1));
  assign ld_ready = (st == S_IDLE);
  assign sd_out   = (st == S_IDLE) ? 1'b1 : (st == S_PEND) ? 1'b0 : sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      sh  <= '0;
      bc  <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (ld_valid) begin
          sh  <= ld_data;
          cnt <= '0;
          st  <= S_PEND;
        end
        default: begin
          if (expire) st <= S_IDLE;
          else begin
            cnt <= cnt + CW'(1);
            if (st == S_PEND) begin
              if (fall) begin
                st <= S_SHIFT;
                bc <= '0;
              end
            end else begin
              if (fall) sh <= sh << 1;
              if (rise) begin
                if (bc == BW'(W - 1)) st <= S_IDLE;
                else                  bc <= bc + BW'(1);
              end
            end
          end
        end
      endcase
    end
  end

  assert_announce_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (!sd_out && !ld_ready));

  assert_first_bit_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && fall && !expire) |=> (sd_out == $past(sh[W-1])));

  assert_done_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && rise && bc == BW'(W - 1)) |=> (ld_ready && sd_out));

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (cnt < win));

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && !fall) |=> $stable(sh));

  assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready && !ld_valid) |=> (sd_out && ld_ready));

endmodule

// File: tb/sim_rx_word_link.sv
module sim_rx_word_link;
  localparam int TN = 600, TM = 500, AN = 560, AM = 460;
  localparam int HP = 4;

  logic clk = 0, rst_n = 0, ld_valid = 0, std_amps = 0, maj_mode = 0, fwd_ctl = 0, sck_in = 1;
  logic [31:0] ld_data = '0;
  logic ld_ready, sd_out;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] got_word;
  string got_tag;
  event got_ev;

  rx_word_link #(.W(32), .WIN_T_NORM(TN), .WIN_T_MAJ(TM), .WIN_A_NORM(AN), .WIN_A_MAJ(AM)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready),
    .std_amps(std_amps), .maj_mode(maj_mode), .fwd_ctl(fwd_ctl), .sck_in(sck_in), .sd_out(sd_out));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(got_ev) begin
    logic [31:0] e;
    string t;
    if (exp_q.size() == 0) chk(0, got_tag, got_word, 32'hx);
    else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got_word == e, t, got_word, e);
    end
  end

  task automatic load(input logic [31:0] w);
    @(negedge clk);
    ld_valid = 1; ld_data = w;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic drive_word(input logic [31:0] w, input string req);
    exp_q.push_back(w);
    tag_q.push_back(req);
    load(w);
  endtask

  task automatic read_bits(input int n, output logic [31:0] bits);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      sck_in = 0;
      repeat (HP) @(negedge clk);
      bits = {bits[30:0], sd_out};
      sck_in = 1;
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic read_word(input string req);
    logic [31:0] b;
    chk(sd_out == 0, "R2 line low before first clock", {31'b0, sd_out}, 0);
    read_bits(32, b);
    chk(sd_out == 1 && ld_ready == 1, "R3 idle after 32 bits", {30'b0, sd_out, ld_ready}, 3);
    got_word = b;
    got_tag = req;
    -> got_ev;
    @(negedge clk);
  endtask

  task automatic measure_window(output int n);
    n = 0;
    while (!ld_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic win_case(input bit a, input bit m, input bit f, input int expn, input string req);
    int n;
    std_amps = a; maj_mode = m; fwd_ctl = f;
    load(32'h1234_5678);
    chk(sd_out == 0, req, {31'b0, sd_out}, 0);
    measure_window(n);
    chk(n == expn, req, n, expn);
    chk(sd_out == 1, req, {31'b0, sd_out}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pb;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sd_out == 1, "R1 line idle high", {31'b0, sd_out}, 1);
    chk(ld_ready == 1, "R1 ready after reset", {31'b0, ld_ready}, 1);

    drive_word(32'hA5A5_5A5A, "R3 alternating word");
    chk(ld_ready == 0, "R2 ready low after accept", {31'b0, ld_ready}, 0);
    read_word("R3 alternating word");
    drive_word(32'h8000_0000, "R3 msb only");
    read_word("R3 msb only");
    drive_word(32'h0000_0001, "R3 lsb only");
    read_word("R3 lsb only");
    drive_word(32'hFFFF_FFFF, "R3 all ones");
    read_word("R3 all ones");
    drive_word(32'h0000_0000, "R3 all zero");
    read_word("R3 all zero");

    win_case(0, 0, 0, TN, "R4 window std0 normal");
    win_case(0, 1, 1, TM, "R4 window std0 majority fwd");
    win_case(1, 0, 0, AN, "R4 window std1 normal");
    win_case(1, 1, 1, AM, "R4 window std1 majority fwd");
    win_case(0, 1, 0, TN, "R5 window std0 majority not fwd");
    win_case(1, 1, 0, AN, "R5 window std1 majority not fwd");
    win_case(1, 0, 1, AN, "R5 window std1 fwd no majority");
    std_amps = 0; maj_mode = 0; fwd_ctl = 0;

    load(32'hC3C3_0F0F);
    read_bits(10, pb);
    chk(pb[9:0] == 10'h30F, "R6 partial bits", {22'b0, pb[9:0]}, 32'h30F);
    measure_window(n);
    chk(n + 10 * 2 * HP == TN, "R6 partial expiry cycles", n + 10 * 2 * HP, TN);
    chk(sd_out == 1, "R6 idle after partial", {31'b0, sd_out}, 1);
    drive_word(32'h1357_9BDF, "R6 word after partial read");
    read_word("R6 word after partial read");

    drive_word(32'hDEAD_BEEF, "R7 held word kept");
    @(negedge clk);
    ld_valid = 1; ld_data = 32'h0BAD_F00D;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ld_ready == 0, "R7 ready low while pending", {31'b0, ld_ready}, 0);
    end
    ld_valid = 0;
    read_word("R7 held word kept");
    drive_word(32'h0BAD_F00D, "R7 second word after clear");
    read_word("R7 second word after clear");

    for (int i = 0; i < 6; i++) begin
      sck_in = 0; repeat (HP) @(negedge clk);
      chk(sd_out == 1 && ld_ready == 1, "R8 idle clocks ignored", {30'b0, sd_out, ld_ready}, 3);
      sck_in = 1; repeat (HP) @(negedge clk);
    end
    drive_word(32'h7E81_24C3, "R8 word after idle clocks");
    read_word("R8 word after idle clocks");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule